// File: doc/BRIEF.md
# Scratchpad and One-Time Register Memory Unit

This unit is the memory-function layer that sits behind a selected slave on a single-wire serial bus. It works only with byte-level strobes. A bit-slot engine hands it each byte received from the bus master. The same engine asks it for the next byte whenever it must send one. The unit holds four storage elements:
- a 32-byte data scratchpad;
- an 8-byte staging area for the application register;
- the 64-bit application register itself, which can be written only once;
- a status byte that shows whether that register has been written.

A transaction starts with an opcode byte. The opcode selects one of six actions: write the data scratchpad, read the data scratchpad, write the staging area, read the application register, copy-and-lock, or read the status byte. The four data-moving commands take a start address byte. After that, bytes stream with an address that increments after each byte and wraps inside its region until the bus master issues a bus reset.

The first copy moves the staging area into the application register. It also clears the two low bits of the status byte, which turns FFh into FCh. Every later copy is refused.

Top module: `otp_scratch_mem`

## Requirements
- R1: After `rstN` is released, `txValid` is low, the data scratchpad and the application register read as 00h, and the status byte reads FFh.
- R2: Opcode `OP_WR_SP` (default 0Fh) takes one address byte and then data bytes. Each data byte is stored at the current address, and the address then increments.
- R3: In the data scratchpad the address after 1Fh is 00h, for both writing and reading, and the stream continues until a bus reset.
- R4: Opcode `OP_RD_SP` (default AAh) takes one address byte. After that, each cycle with `txReq` high causes `txValid` to be high on the next cycle, with `txByte` holding the scratchpad byte at the current address, and the address then increments.
- R5: Only bits [4:0] of a data scratchpad address byte are used. For example, E5h selects address 05h.
- R6: Opcode `OP_WR_RG` (default 99h) takes an address byte, of which bits [2:0] are used, and then writes bytes into the 8-byte staging area. The address wraps from 7 to 0.
- R7: Opcode `OP_RD_RG` (default C3h) takes an address byte, of which bits [2:0] are used, and then returns application register bytes on each `txReq`. The address wraps from 7 to 0.
- R8: Opcode `OP_COPY` (default 5Ah), issued while status bits [1:0] are 11, copies the staging area into the application register and makes the status byte FCh.
- R9: Opcode `OP_COPY` issued while status bits [1:0] are 00 leaves the application register and the status byte unchanged.
- R10: Opcode `OP_STATUS` (default 66h) returns the status byte on every following `txReq`. The status byte is {6'b111111, lock bits}.
- R11: A `busReset` pulse aborts the current command, and the next received byte is decoded as an opcode. If `busReset` and `rxValid` are high in the same cycle, `busReset` wins and the byte is discarded.
- R12: The data scratchpad can be rewritten any number of times, and its contents survive `busReset`.
- R13: A `txReq` outside a read phase produces no `txValid`. A received byte during a read phase changes neither the memory nor the address. An unknown opcode causes every byte to be ignored until `busReset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; sets the register to unprogrammed |
| busReset | input | 1 | One-cycle strobe: bus reset seen by the bit-slot engine |
| rxValid | input | 1 | One-cycle strobe: `rxByte` holds a received byte |
| rxByte | input | 8 | Byte received from the bus master |
| txReq | input | 1 | One-cycle strobe: the engine needs the next byte to send |
| txValid | output | 1 | High one cycle after an accepted `txReq` |
| txByte | output | 8 | Byte to send, valid while `txValid` is high |

## Verification
The bench drives streams that cross the 1Fh-to-00h boundary and the 7-to-0 boundary. A design with a wrong counter width would either write past the end of the page or jump to a byte that was never written. It sends address bytes with the upper bits set, which catch a decoder that uses the whole byte. It also repeats the copy after the lock is set, where a design with a broken lock overwrites the application register or changes FCh. Bus resets are placed in the middle of a stream and in the same cycle as a data byte. A design that gets this wrong would take that byte as data, or would decode the next opcode as an address.

// File: rtl/otp_scratch_pkg.sv
package otp_scratch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_XFER,
    ST_STAT,
    ST_HOLD
  } ctrlState_t;

  typedef enum logic [1:0] {
    MD_SP_WR,
    MD_SP_RD,
    MD_RG_WR,
    MD_RG_RD
  } xferMode_t;

  typedef enum logic [1:0] {
    TX_SP,
    TX_RG,
    TX_STAT
  } txSrc_t;

  typedef struct packed {
    logic   addrLoad;
    logic   addrInc;
    logic   spWr;
    logic   rgWr;
    logic   copyReg;
    logic   txLoad;
    txSrc_t txSrc;
  } ctrlStrobe_t;

endpackage

// File: rtl/otp_scratch_ctrl.sv
module otp_scratch_ctrl
  import otp_scratch_pkg::*;
#(
  parameter logic [7:0] OP_WR_SP  = 8'h0F,
  parameter logic [7:0] OP_RD_SP  = 8'hAA,
  parameter logic [7:0] OP_WR_RG  = 8'h99,
  parameter logic [7:0] OP_RD_RG  = 8'hC3,
  parameter logic [7:0] OP_COPY   = 8'h5A,
  parameter logic [7:0] OP_STATUS = 8'h66
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busReset,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  input  logic        txReq,
  output ctrlStrobe_t strb
);

  ctrlState_t state, stateNext;
  xferMode_t  mode, modeNext;

  always_comb begin
    stateNext = state;
    modeNext  = mode;
    strb      = '0;
    if (busReset) begin
      stateNext = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (rxValid) begin
            if (rxByte == OP_WR_SP) begin
              modeNext = MD_SP_WR; stateNext = ST_ADDR;
            end else if (rxByte == OP_RD_SP) begin
              modeNext = MD_SP_RD; stateNext = ST_ADDR;
            end else if (rxByte == OP_WR_RG) begin
              modeNext = MD_RG_WR; stateNext = ST_ADDR;
            end else if (rxByte == OP_RD_RG) begin
              modeNext = MD_RG_RD; stateNext = ST_ADDR;
            end else if (rxByte == OP_COPY) begin
              strb.copyReg = 1'b1; stateNext = ST_HOLD;
            end else if (rxByte == OP_STATUS) begin
              stateNext = ST_STAT;
            end else begin
              stateNext = ST_HOLD;
            end
          end
        end
        ST_ADDR: begin
          if (rxValid) begin
            strb.addrLoad = 1'b1;
            stateNext     = ST_XFER;
          end
        end
        ST_XFER: begin
          case (mode)
            MD_SP_WR: if (rxValid) begin
              strb.spWr = 1'b1; strb.addrInc = 1'b1;
            end
            MD_RG_WR: if (rxValid) begin
              strb.rgWr = 1'b1; strb.addrInc = 1'b1;
            end
            MD_SP_RD: if (txReq) begin
              strb.txLoad = 1'b1; strb.txSrc = TX_SP; strb.addrInc = 1'b1;
            end
            default: if (txReq) begin
              strb.txLoad = 1'b1; strb.txSrc = TX_RG; strb.addrInc = 1'b1;
            end
          endcase
        end
        ST_STAT: begin
          if (txReq) begin
            strb.txLoad = 1'b1;
            strb.txSrc  = TX_STAT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      mode  <= MD_SP_WR;
    end else begin
      state <= stateNext;
      mode  <= modeNext;
    end
  end

  // R11: a bus reset always returns the sequencer to opcode decoding
  a_r11_abort_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (state == ST_IDLE));

  // R13: a byte can only be loaded for sending in a read phase
  a_r13_tx_only_in_read: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLoad |-> (state == ST_STAT ||
                     (state == ST_XFER && (mode == MD_SP_RD || mode == MD_RG_RD))));

  // R13: an unknown opcode leaves the sequencer parked until a bus reset
  a_r13_hold_parks: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !busReset) |=> (state == ST_HOLD));

endmodule

// File: rtl/otp_scratch_dpath.sv
module otp_scratch_dpath
  import otp_scratch_pkg::*;
#(
  parameter int SP_BYTES = 32,
  parameter int RG_BYTES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strb,
  input  logic [7:0]  rxByte,
  output logic        txValid,
  output logic [7:0]  txByte
);

  localparam int ADDR_W = $clog2(SP_BYTES);
  localparam int RG_AW  = $clog2(RG_BYTES);

  logic [ADDR_W-1:0]         addr;
  logic [7:0]                spMem [SP_BYTES];
  logic [RG_BYTES-1:0][7:0]  rgStage;
  logic [RG_BYTES-1:0][7:0]  appReg;
  logic [1:0]                lockBits;
  logic [7:0]                statusByte;
  logic [7:0]                txMux;
  logic [RG_AW-1:0]          rgIdx;

  assign rgIdx      = addr[RG_AW-1:0];
  assign statusByte = {6'b111111, lockBits};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr <= '0;
    end else if (strb.addrLoad) begin
      addr <= rxByte[ADDR_W-1:0];
    end else if (strb.addrInc) begin
      addr <= addr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SP_BYTES; i++) spMem[i] <= '0;
    end else if (strb.spWr) begin
      spMem[addr] <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rgStage  <= '0;
      appReg   <= '0;
      lockBits <= 2'b11;
    end else begin
      if (strb.rgWr) rgStage[rgIdx] <= rxByte;
      if (strb.copyReg && lockBits == 2'b11) begin
        appReg   <= rgStage;
        lockBits <= 2'b00;
      end
    end
  end

  always_comb begin
    case (strb.txSrc)
      TX_SP:   txMux = spMem[addr];
      TX_RG:   txMux = appReg[rgIdx];
      default: txMux = statusByte;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txByte  <= '0;
    end else begin
      txValid <= strb.txLoad;
      if (strb.txLoad) txByte <= txMux;
    end
  end

  // R3: stepping past the last scratchpad byte lands on byte zero
  a_r3_addr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.addrInc && !strb.addrLoad && addr == {ADDR_W{1'b1}}) |=> (addr == '0));

  // R8: a copy into an unprogrammed register locks it
  a_r8_copy_locks: assert property (@(posedge clk) disable iff (!rstN)
    (strb.copyReg && lockBits == 2'b11) |=> (lockBits == 2'b00));

  // R9: once locked, the lock and the register contents never change
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (lockBits == 2'b00) |=> (lockBits == 2'b00 && $stable(appReg)));

  // R12: the data scratchpad never changes without a write strobe
  a_r12_sp_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.spWr |=> $stable(spMem[0]));

endmodule

// File: rtl/otp_scratch_mem.sv
module otp_scratch_mem
  import otp_scratch_pkg::*;
#(
  parameter int         SP_BYTES  = 32,
  parameter int         RG_BYTES  = 8,
  parameter logic [7:0] OP_WR_SP  = 8'h0F,
  parameter logic [7:0] OP_RD_SP  = 8'hAA,
  parameter logic [7:0] OP_WR_RG  = 8'h99,
  parameter logic [7:0] OP_RD_RG  = 8'hC3,
  parameter logic [7:0] OP_COPY   = 8'h5A,
  parameter logic [7:0] OP_STATUS = 8'h66
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReset,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       txReq,
  output logic       txValid,
  output logic [7:0] txByte
);

  ctrlStrobe_t strb;

  otp_scratch_ctrl #(
    .OP_WR_SP(OP_WR_SP), .OP_RD_SP(OP_RD_SP), .OP_WR_RG(OP_WR_RG),
    .OP_RD_RG(OP_RD_RG), .OP_COPY(OP_COPY), .OP_STATUS(OP_STATUS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busReset(busReset), .rxValid(rxValid),
    .rxByte(rxByte), .txReq(txReq), .strb(strb)
  );

  otp_scratch_dpath #(.SP_BYTES(SP_BYTES), .RG_BYTES(RG_BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte),
    .txValid(txValid), .txByte(txByte)
  );

  // R4: a byte is presented only in answer to a request one cycle earlier
  a_r4_tx_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(txReq));

endmodule

// File: tb/otp_scratch_mem_tb.sv
module otp_scratch_mem_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busReset = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       txReq = 1'b0;
  logic       txValid;
  logic [7:0] txByte;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mSp [32];
  logic [7:0] mStage [8];
  logic [7:0] mApp [8];
  logic [7:0] mStatus;

  always #2.5 clk = ~clk;

  otp_scratch_mem u_dut (
    .clk(clk), .rstN(rstN), .busReset(busReset), .rxValid(rxValid),
    .rxByte(rxByte), .txReq(txReq), .txValid(txValid), .txByte(txByte)
  );

  function automatic logic [4:0] spAddr(logic [7:0] a);
    return a[4:0];
  endfunction

  function automatic logic [2:0] rgAddr(logic [7:0] a);
    return a[2:0];
  endfunction

  task automatic sendByte(logic [7:0] b);
    @(negedge clk); rxValid = 1'b1; rxByte = b;
    @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic busRst();
    @(negedge clk); busReset = 1'b1;
    @(negedge clk); busReset = 1'b0;
  endtask

  task automatic rdChk(string req, logic [7:0] exp);
    @(negedge clk); txReq = 1'b1;
    @(negedge clk); txReq = 1'b0;
    checks++;
    if (!txValid || txByte !== exp) begin
      fails++;
      $display("FAIL %s: actual valid=%0b byte=%h expected valid=1 byte=%h",
               req, txValid, txByte, exp);
    end
  endtask

  task automatic noTxChk(string req);
    @(negedge clk); txReq = 1'b1;
    @(negedge clk); txReq = 1'b0;
    checks++;
    if (txValid !== 1'b0) begin
      fails++;
      $display("FAIL %s: actual valid=%0b expected valid=0", req, txValid);
    end
  endtask

  task automatic spWrite(logic [7:0] a, int n, logic [7:0] first, bit rnd);
    logic [4:0] p;
    logic [7:0] d;
    busRst(); sendByte(8'h0F); sendByte(a);
    p = spAddr(a);
    for (int i = 0; i < n; i++) begin
      d = rnd ? 8'($urandom) : first + 8'(i);
      sendByte(d); mSp[p] = d; p = p + 5'd1;
    end
  endtask

  task automatic spRead(string req, logic [7:0] a, int n);
    logic [4:0] p;
    busRst(); sendByte(8'hAA); sendByte(a);
    p = spAddr(a);
    for (int i = 0; i < n; i++) begin
      rdChk(req, mSp[p]); p = p + 5'd1;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [2:0] q;
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) mSp[i] = 8'h00;
    for (int i = 0; i < 8; i++) begin mStage[i] = 8'h00; mApp[i] = 8'h00; end
    mStatus = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    checks++;
    if (txValid !== 1'b0) begin
      fails++; $display("FAIL R1: actual txValid=%0b expected 0", txValid);
    end
    busRst(); sendByte(8'h66);
    rdChk("R1 status after reset", 8'hFF);
    rdChk("R10 status repeats", 8'hFF);
    spRead("R1 scratchpad cleared", 8'h00, 3);
    busRst(); sendByte(8'hC3); sendByte(8'h00);
    rdChk("R1 app register cleared", 8'h00);

    // R2, R3: write across the page end, read back across it
    spWrite(8'h1E, 4, 8'hA1, 1'b0);
    spRead("R3 wrap", 8'h1E, 4);
    spRead("R2 write stream", 8'h00, 2);

    // R5: upper address bits ignored
    spWrite(8'hE5, 1, 8'h5C, 1'b0);
    spRead("R5 low five bits", 8'h25, 1);

    // R13: txReq during a write phase gives nothing
    busRst(); sendByte(8'h0F); sendByte(8'h00);
    noTxChk("R13 txReq in write phase");
    busRst();
    noTxChk("R13 txReq while idle");
    // R13: received byte during read phase is ignored
    busRst(); sendByte(8'hAA); sendByte(8'h10);
    rdChk("R13 read before stray byte", mSp[16]);
    sendByte(8'h77);
    rdChk("R13 address not moved by stray byte", mSp[17]);
    spRead("R13 memory not written by stray byte", 8'h10, 2);
    // R13: unknown opcode parks until reset
    busRst(); sendByte(8'h3C); sendByte(8'h0F); sendByte(8'h00); sendByte(8'hEE);
    noTxChk("R13 unknown opcode no tx");
    spRead("R13 unknown opcode no write", 8'h00, 1);

    // R11: abort in mid-stream, next byte is an opcode
    busRst(); sendByte(8'h0F); sendByte(8'h08); sendByte(8'h11); mSp[8] = 8'h11;
    busRst(); sendByte(8'hAA); sendByte(8'h08);
    rdChk("R11 abort then opcode", 8'h11);
    // R11: reset and byte together, byte discarded
    busRst(); sendByte(8'h0F); sendByte(8'h09);
    @(negedge clk); busReset = 1'b1; rxValid = 1'b1; rxByte = 8'h55;
    @(negedge clk); busReset = 1'b0; rxValid = 1'b0;
    sendByte(8'hAA); sendByte(8'h09);
    rdChk("R11 reset wins over byte", mSp[9]);

    // R6: staging area write with wrap from 7 to 0
    busRst(); sendByte(8'h99); sendByte(8'hF6);
    q = rgAddr(8'hF6);
    for (int i = 0; i < 8; i++) begin
      mStage[q] = 8'hC0 + 8'(i); sendByte(8'hC0 + 8'(i)); q = q + 3'd1;
    end
    busRst(); sendByte(8'hC3); sendByte(8'h06);
    rdChk("R7 app register untouched before copy", 8'h00);
    // R8: copy locks
    busRst(); sendByte(8'h5A);
    for (int i = 0; i < 8; i++) mApp[i] = mStage[i];
    mStatus = 8'hFC;
    busRst(); sendByte(8'h66);
    rdChk("R8 status after copy", mStatus);
    // R7, R6: read app register wrapping, checks staging order too
    busRst(); sendByte(8'hC3); sendByte(8'hFE);
    q = 3'd6;
    for (int i = 0; i < 9; i++) begin
      rdChk("R7 R6 app register read wrap", mApp[q]); q = q + 3'd1;
    end

    // R9: second copy refused
    busRst(); sendByte(8'h99); sendByte(8'h00);
    for (int i = 0; i < 8; i++) sendByte(8'h30 + 8'(i));
    busRst(); sendByte(8'h5A);
    busRst(); sendByte(8'hC3); sendByte(8'h00);
    for (int i = 0; i < 8; i++) rdChk("R9 app register after refused copy", mApp[i]);
    busRst(); sendByte(8'h66);
    rdChk("R9 status stays", 8'hFC);

    // R12: random rewrites and reads
    for (int k = 0; k < 24; k++) begin
      spWrite(8'($urandom), 1 + int'($urandom % 40), 8'h00, 1'b1);
      spRead("R12 random rewrite", 8'($urandom), 1 + int'($urandom % 40));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule